// File: doc/BRIEF.md
# Conservative Open-Page Bypass Decision Unit

This unit sits beside the command player of a pattern-based SDRAM back-end. For every bank it remembers whether a row is open and which row that is. Each pattern has one slot, the precharge slot, placed as late as the timing rules allow. At that slot the unit looks at the request that will be served next. If that request is already known and targets the row that is still open in its bank, the unit issues a bypass. The command player then skips the precharge and the next activate, and resumes the following pattern at its first column command.

In every other case the unit issues the precharge exactly as a close-page controller would. That covers a row miss, a closed bank, and a next request that has not arrived by the slot. The worst case therefore never differs from close-page operation, and a bypass can only shorten service. The decision is taken once per pattern and is never revised.

The bank and row of the next request are cut out of the logical address with the same shift amounts the address generator uses. Refresh closes every bank.

Top module: `cop_bypass_ctrl`

## Requirements
- R1: After reset, `bypass` and `do_pre` are low and every bank is closed, so the first decision after reset is a precharge whatever the next address is.
- R2: At a decision slot, if `nxt_vld` is high and the next request's row equals the open row of its bank, then `bypass` pulses high for one cycle on the cycle after the slot and `resume_pos` equals `FIRST_COL_POS` (default 9).
- R3: At a decision slot, a next request whose row differs from the open row of its bank gives a one-cycle `do_pre` pulse on the cycle after the slot, with `resume_pos` equal to 0.
- R4: At a decision slot with `nxt_vld` low, the result is a `do_pre` pulse, as in R3.
- R5: A decision is taken only in a cycle where `pat_active` is high and `pat_pos` equals `PRE_SLOT` (default 34). Each such cycle gives exactly one pulse, on `bypass` or on `do_pre`, never both. A next request that arrives after the slot changes nothing.
- R6: A `do_pre` decision closes bank `cur_bank`, so a later request to the same row of that bank is a miss until the row is activated again.
- R7: A bypass leaves the open-row state unchanged, so a repeated hit on the same row bypasses again.
- R8: A `refresh` pulse closes all banks.
- R9: An `act_vld` pulse records `act_row` as open in bank `act_bank`. Each bank's state is independent of the others.
- R10: The bank is address bits [BANK_SHIFT +: BANK_W] (default bits 12:10) and the row is bits [ROW_SHIFT +: ROW_W] (default bits 26:13). The same row in another bank is a miss unless that bank has that row open.
- R11: `pre_bank` gives the value of `cur_bank` at the decision slot, and is valid together with the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| nxt_vld | input | 1 | Next request address is known |
| nxt_addr | input | ADDR_W | Logical address of next request |
| pat_active | input | 1 | A pattern is being played |
| pat_pos | input | POS_W | Current position in the pattern |
| cur_bank | input | BANK_W | Bank served by the current pattern |
| act_vld | input | 1 | An activate is issued this cycle |
| act_bank | input | BANK_W | Bank of that activate |
| act_row | input | ROW_W | Row of that activate |
| refresh | input | 1 | A refresh is issued; all banks close |
| bypass | output | 1 | Skip precharge and activate (one-cycle pulse) |
| do_pre | output | 1 | Issue the precharge (one-cycle pulse) |
| pre_bank | output | BANK_W | Bank the decision applies to |
| resume_pos | output | POS_W | Entry at which the next pattern starts |

## Verification
The assertions assume that `pat_active` and `pat_pos` come from a well-behaved command player, and that `refresh` never coincides with a decision slot. They also assume that an activate is only issued to a bank that is closed. The bench keeps to these rules. It raises the slot for a single cycle per pattern and issues activates only between decisions. It drives refresh alone, and issues no activate between a refresh and the next decision. Stray slot positions, an inactive pattern at the slot position and a late-arriving next address are all driven, and the bench checks that none of them produces a pulse.

// File: rtl/cop_pkg.sv
// Package: shared types for the conservative open-page bypass unit.
// Assumes: nothing beyond IEEE 1800-2017.
package cop_pkg;
    // Outcome of one precharge-slot decision.
    typedef enum logic [1:0] {
        DEC_NONE      = 2'b00,
        DEC_BYPASS    = 2'b01,
        DEC_PRECHARGE = 2'b10
    } dec_e;
endpackage

// File: rtl/cop_addr_split.sv
// Module: extracts the bank and row fields from a logical address.
// Assumes: the shifts match those used by the address generator; the fields
// fit inside ADDR_W.
module cop_addr_split #(
    parameter int ADDR_W     = 28,
    parameter int BANK_W     = 3,
    parameter int ROW_W      = 14,
    parameter int BANK_SHIFT = 10,
    parameter int ROW_SHIFT  = 13
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [BANK_W-1:0] bank,
    output logic [ROW_W-1:0]  row
);
    // Shift-and-truncate field extraction.
    always_comb begin
        bank = BANK_W'(addr >> BANK_SHIFT);
        row  = ROW_W'(addr >> ROW_SHIFT);
    end
endmodule

// File: rtl/cop_open_rows.sv
// Module: per-bank open-row register and valid bit.
// Assumes: refresh and an activate never target a bank in the same cycle
// (refresh wins if they do); close and activate on one bank: activate wins.
module cop_open_rows #(
    parameter int NUM_BANKS = 8,
    parameter int ROW_W     = 14,
    localparam int BANK_W   = $clog2(NUM_BANKS)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            close_en,
    input  logic [BANK_W-1:0]               close_bank,
    input  logic                            act_vld,
    input  logic [BANK_W-1:0]               act_bank,
    input  logic [ROW_W-1:0]                act_row,
    input  logic                            refresh,
    output logic [NUM_BANKS-1:0]            row_vld,
    output logic [NUM_BANKS-1:0][ROW_W-1:0] row_id
);
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic is_act, is_close;
        assign is_act   = act_vld  && (act_bank   == BANK_W'(b));
        assign is_close = close_en && (close_bank == BANK_W'(b));

        // Track open row of this bank: refresh > activate > close.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                row_vld[b] <= 1'b0;
                row_id[b]  <= '0;
            end else if (refresh) begin
                row_vld[b] <= 1'b0;
            end else if (is_act) begin
                row_vld[b] <= 1'b1;
                row_id[b]  <= act_row;
            end else if (is_close) begin
                row_vld[b] <= 1'b0;
            end
        end
    end

    // Refresh leaves every bank closed.
    assert_refresh_closes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        refresh |=> (row_vld == '0));

    // An activate opens its bank with the given row.
    assert_act_opens_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (act_vld && !refresh) |=> (row_vld[$past(act_bank)] && row_id[$past(act_bank)] == $past(act_row)));
endmodule

// File: rtl/cop_decide.sv
// Module: samples the hit test once at the precharge slot and emits a
// one-cycle bypass or precharge pulse.
// Assumes: pat_pos steps through the pattern; the slot is seen once per pattern.
module cop_decide
    import cop_pkg::*;
#(
    parameter int NUM_BANKS     = 8,
    parameter int ROW_W         = 14,
    parameter int POS_W         = 6,
    parameter int PRE_SLOT      = 34,
    parameter int FIRST_COL_POS = 9,
    localparam int BANK_W       = $clog2(NUM_BANKS)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            pat_active,
    input  logic [POS_W-1:0]                pat_pos,
    input  logic [BANK_W-1:0]               cur_bank,
    input  logic                            nxt_vld,
    input  logic [BANK_W-1:0]               nxt_bank,
    input  logic [ROW_W-1:0]                nxt_row,
    input  logic [NUM_BANKS-1:0]            row_vld,
    input  logic [NUM_BANKS-1:0][ROW_W-1:0] row_id,
    output logic                            close_en,
    output logic                            bypass,
    output logic                            do_pre,
    output logic [BANK_W-1:0]               pre_bank,
    output logic [POS_W-1:0]                resume_pos
);
    logic slot, hit;
    dec_e dec_q;

    // Decision cycle and row-hit test for the next request.
    always_comb begin
        slot     = pat_active && (pat_pos == POS_W'(PRE_SLOT));
        hit      = nxt_vld && row_vld[nxt_bank] && (row_id[nxt_bank] == nxt_row);
        close_en = slot && !hit;
    end

    // Register the single decision taken at the slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_q      <= DEC_NONE;
            pre_bank   <= '0;
            resume_pos <= '0;
        end else if (slot) begin
            dec_q      <= hit ? DEC_BYPASS : DEC_PRECHARGE;
            pre_bank   <= cur_bank;
            resume_pos <= hit ? POS_W'(FIRST_COL_POS) : '0;
        end else begin
            dec_q      <= DEC_NONE;
        end
    end

    assign bypass = (dec_q == DEC_BYPASS);
    assign do_pre = (dec_q == DEC_PRECHARGE);

    // Never both pulses at once.
    assert_one_outcome_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bypass, do_pre}));

    // Every slot gives exactly one pulse in the next cycle.
    assert_slot_pulses_R5: assert property (@(posedge clk) disable iff (!rst_n)
        slot |=> (bypass || do_pre));

    // No pulse without a slot.
    assert_no_stray_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !slot |=> !(bypass || do_pre));

    // Unknown next request always falls back to precharge.
    assert_unknown_pre_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (slot && !nxt_vld) |=> (do_pre && resume_pos == '0));
endmodule

// File: rtl/cop_bypass_ctrl.sv
// Module: top of the conservative open-page bypass unit; ties address
// extraction, per-bank open-row state and slot decision together.
// Assumes: act/refresh inputs mirror commands actually issued to the device.
module cop_bypass_ctrl #(
    parameter int NUM_BANKS     = 8,
    parameter int ROW_W         = 14,
    parameter int ADDR_W        = 28,
    parameter int BANK_SHIFT    = 10,
    parameter int ROW_SHIFT     = 13,
    parameter int POS_W         = 6,
    parameter int PRE_SLOT      = 34,
    parameter int FIRST_COL_POS = 9,
    localparam int BANK_W       = $clog2(NUM_BANKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nxt_vld,
    input  logic [ADDR_W-1:0] nxt_addr,
    input  logic              pat_active,
    input  logic [POS_W-1:0]  pat_pos,
    input  logic [BANK_W-1:0] cur_bank,
    input  logic              act_vld,
    input  logic [BANK_W-1:0] act_bank,
    input  logic [ROW_W-1:0]  act_row,
    input  logic              refresh,
    output logic              bypass,
    output logic              do_pre,
    output logic [BANK_W-1:0] pre_bank,
    output logic [POS_W-1:0]  resume_pos
);
    logic [BANK_W-1:0]               nxt_bank;
    logic [ROW_W-1:0]                nxt_row;
    logic [NUM_BANKS-1:0]            row_vld;
    logic [NUM_BANKS-1:0][ROW_W-1:0] row_id;
    logic                            close_en;

    cop_addr_split #(
        .ADDR_W(ADDR_W), .BANK_W(BANK_W), .ROW_W(ROW_W),
        .BANK_SHIFT(BANK_SHIFT), .ROW_SHIFT(ROW_SHIFT)
    ) u_split (
        .addr(nxt_addr), .bank(nxt_bank), .row(nxt_row)
    );

    cop_open_rows #(.NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W)) u_rows (
        .clk(clk), .rst_n(rst_n),
        .close_en(close_en), .close_bank(cur_bank),
        .act_vld(act_vld), .act_bank(act_bank), .act_row(act_row),
        .refresh(refresh),
        .row_vld(row_vld), .row_id(row_id)
    );

    cop_decide #(
        .NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W), .POS_W(POS_W),
        .PRE_SLOT(PRE_SLOT), .FIRST_COL_POS(FIRST_COL_POS)
    ) u_decide (
        .clk(clk), .rst_n(rst_n),
        .pat_active(pat_active), .pat_pos(pat_pos), .cur_bank(cur_bank),
        .nxt_vld(nxt_vld), .nxt_bank(nxt_bank), .nxt_row(nxt_row),
        .row_vld(row_vld), .row_id(row_id),
        .close_en(close_en),
        .bypass(bypass), .do_pre(do_pre),
        .pre_bank(pre_bank), .resume_pos(resume_pos)
    );

    // A bypass reports the column-command entry, a precharge reports entry 0.
    assert_resume_matches_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bypass |-> resume_pos == POS_W'(FIRST_COL_POS)) and (do_pre |-> resume_pos == '0));
endmodule

// File: tb/cop_bypass_ctrl_tb.sv
// Scoreboard bench: decision tasks push expected outcomes; a monitor pops
// and compares each pulse the design produces.
module cop_bypass_ctrl_tb;
    localparam int ADDR_W = 28, BANK_W = 3, ROW_W = 14, POS_W = 6;
    localparam int SLOT = 34, COLPOS = 9;

    logic clk = 1'b0, rst_n = 1'b0;
    logic nxt_vld = 1'b0, pat_active = 1'b0, act_vld = 1'b0, refresh = 1'b0;
    logic [ADDR_W-1:0] nxt_addr = '0;
    logic [POS_W-1:0]  pat_pos = '0;
    logic [BANK_W-1:0] cur_bank = '0, act_bank = '0;
    logic [ROW_W-1:0]  act_row = '0;
    logic bypass, do_pre;
    logic [BANK_W-1:0] pre_bank;
    logic [POS_W-1:0]  resume_pos;

    int checks = 0, fails = 0;
    logic [10:0] exp_q[$];   // {byp, pre, bank[2:0], resume[5:0]}
    string       tag_q[$];

    always #5 clk = ~clk;

    cop_bypass_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .nxt_vld(nxt_vld), .nxt_addr(nxt_addr),
        .pat_active(pat_active), .pat_pos(pat_pos), .cur_bank(cur_bank),
        .act_vld(act_vld), .act_bank(act_bank), .act_row(act_row),
        .refresh(refresh), .bypass(bypass), .do_pre(do_pre),
        .pre_bank(pre_bank), .resume_pos(resume_pos)
    );

    function automatic logic [ADDR_W-1:0] mk(int bank, int row);
        return ADDR_W'((row << 13) | (bank << 10) | 5);
    endfunction

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: compare every pulse with the head of the scoreboard.
    always @(negedge clk) begin
        if (rst_n && (bypass || do_pre)) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R5 unexpected pulse", {bypass, do_pre}, 0);
            end else begin
                logic [10:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk({bypass, do_pre, pre_bank, resume_pos} == e, t,
                    {bypass, do_pre, pre_bank, resume_pos}, e);
            end
        end
    end

    task automatic activate(int bank, int row);
        @(negedge clk);
        act_vld = 1'b1; act_bank = BANK_W'(bank); act_row = ROW_W'(row);
        @(negedge clk);
        act_vld = 1'b0;
    endtask

    task automatic do_refresh();
        @(negedge clk);
        refresh = 1'b1;
        @(negedge clk);
        refresh = 1'b0;
    endtask

    // Driver: one decision slot, expected outcome pushed to the scoreboard.
    task automatic decide(bit vld, int bank, int row, int cb, bit exp_byp, string tag);
        @(negedge clk);
        nxt_vld = vld; nxt_addr = mk(bank, row); cur_bank = BANK_W'(cb);
        pat_active = 1'b1; pat_pos = POS_W'(SLOT);
        exp_q.push_back({exp_byp, !exp_byp, BANK_W'(cb),
                         exp_byp ? POS_W'(COLPOS) : POS_W'(0)});
        tag_q.push_back(tag);
        @(negedge clk);
        pat_pos = '0;
        @(negedge clk);
        nxt_vld = 1'b0; pat_active = 1'b0;
    endtask

    // No pulse expected for n cycles.
    task automatic quiet(int n, string tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(!(bypass || do_pre), tag, {bypass, do_pre}, 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!bypass && !do_pre, "R1 reset outputs", {bypass, do_pre}, 0);
        rst_n = 1'b1;
        quiet(2, "R1 idle after reset");

        decide(1, 2, 5, 2, 0, "R1 closed after reset");
        activate(2, 5);
        decide(1, 2, 5, 2, 1, "R2 hit bypasses, R11 bank");
        decide(1, 2, 5, 2, 1, "R7 bypass keeps row open");
        decide(1, 2, 6, 2, 0, "R3 row miss precharges");
        decide(1, 2, 5, 2, 0, "R6 bank closed by precharge");

        activate(2, 5);
        activate(4, 7);
        decide(0, 2, 5, 2, 0, "R4 unknown next precharges");
        decide(1, 4, 7, 4, 1, "R9 other bank independent");
        decide(1, 5, 7, 4, 0, "R10 same row other bank misses");

        activate(3, 11);
        activate(6, 11);
        do_refresh();
        decide(1, 3, 11, 3, 0, "R8 refresh closes bank 3");
        decide(1, 6, 11, 6, 0, "R8 refresh closes bank 6");

        // R5: wrong position, inactive pattern, late arrival.
        activate(0, 1);
        @(negedge clk);
        nxt_vld = 1'b1; nxt_addr = mk(0, 1); cur_bank = '0;
        pat_active = 1'b1; pat_pos = POS_W'(SLOT - 1);
        quiet(1, "R5 no decision off slot");
        pat_pos = POS_W'(SLOT + 1);
        quiet(1, "R5 no decision past slot");
        pat_active = 1'b0; pat_pos = POS_W'(SLOT);
        quiet(2, "R5 no decision when inactive");
        pat_pos = '0; nxt_vld = 1'b0;

        @(negedge clk);
        pat_active = 1'b1; pat_pos = POS_W'(SLOT); nxt_vld = 1'b0;
        exp_q.push_back({1'b0, 1'b1, 3'd0, 6'd0});
        tag_q.push_back("R5 late next does not revise");
        @(negedge clk);
        pat_pos = POS_W'(SLOT + 1); nxt_vld = 1'b1; nxt_addr = mk(0, 1);
        @(negedge clk);
        quiet(3, "R5 single pulse per slot");
        pat_active = 1'b0; nxt_vld = 1'b0;

        decide(1, 0, 1, 0, 0, "R6 bank 0 closed by late-case precharge");

        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R5 all expected pulses seen", exp_q.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule